// File: doc/BRIEF.md
# Receive FIFO Overrun Handler

This block sits between the receive side of an Ethernet MAC and the FIFO that a DMA engine drains. Bytes arrive one per cycle with start-of-frame and end-of-frame marks. The block writes each byte to the FIFO in the cycle it arrives. In the cycle after the last byte it writes one status entry that carries the frame's byte count. The input cannot be stalled, so the upstream side leaves at least one idle cycle after every end-of-frame byte.

A byte can arrive while the FIFO reports full. When that happens, the block stops storing that frame and discards every remaining byte of it. It then waits until space returns. While it waits, any new frame that starts is dropped completely. When the full flag drops, the block writes a single status entry with the overrun flag set, so software knows to throw that frame away. A saturating counter records each frame that lost data, for diagnostics.

Each FIFO entry uses a kind bit at the top, bit `PAY_W`, which is 13 with the default parameters. A value of 0 marks a data entry, with the byte in bits `[DATA_W-1:0]` and zeros above it. A value of 1 marks a status entry, with the overrun flag at bit `LEN_W` and the byte count in bits `[LEN_W-1:0]`.

Top module: `rxov_handler`

## Requirements
- R1: After a synchronous reset, `drop_count` is 0 and the block is idle. No status entry is written until a new frame has been received.
- R2: A byte that arrives with `fifo_full` low, and that starts or continues an accepted frame, is written in the same cycle. Its entry has kind 0 and the byte in the low bits.
- R3: In the cycle after an accepted end-of-frame byte, if `fifo_full` is low, a status entry is written. It has kind 1, overrun flag 0, and a count equal to the number of bytes written for that frame.
- R4: `fifo_wr` is never high while `fifo_full` is high. After the first byte that meets a full FIFO, no further byte of that frame is written, even if space returns before the frame ends.
- R5: After an overrun frame has ended, exactly one status entry is written in the first cycle that `fifo_full` is low. It has kind 1, overrun flag 1, and the count of bytes written before the overrun. The count is 0 when the first byte already met a full FIFO.
- R6: A frame that starts while the overrun status entry is still pending is dropped whole. None of its bytes is written, including bytes that arrive after space returns. It adds no second status entry.
- R7: `drop_count` rises by exactly 1 for each frame that loses data: the overrun frame and each frame dropped while pending. It saturates at its maximum value.
- R8: If space returns in the same cycle that a new frame starts while pending, the overrun status entry is written in that cycle. The new frame is dropped and counted.
- R9: A frame whose start arrives after the overrun status entry has been written is received normally.
- R10: If `fifo_full` is high in the cycle a normal status entry is due, that status entry is held back. It is later written with the overrun flag set, as in R5.
- R11: Bytes that arrive while idle without a start-of-frame mark are ignored and write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_sof | input | 1 | The byte is the first of a frame |
| in_eof | input | 1 | The byte is the last of a frame |
| in_data | input | DATA_W | Received byte |
| fifo_full | input | 1 | The receive FIFO has no free entry |
| fifo_wr | output | 1 | Write strobe for the FIFO |
| fifo_wdata | output | PAY_W+1 | FIFO entry: kind bit at the top, payload below |
| drop_count | output | CNT_W | Saturating count of frames that lost data |

## Verification
Two functions can fall in the same cycle: writing the deferred overrun status entry, and dropping a frame that begins while that entry is pending. The bench provokes this by holding `fifo_full` high through a whole dropped frame. It then lowers `fifo_full` in the very cycle that the next start-of-frame byte arrives. The result is judged on three points: the status entry must appear in that cycle with the overrun flag set and the old byte count, the counter must step by exactly one, and none of the new frame's later bytes may reach the FIFO.

// File: rtl/rxov_pkg.sv
package rxov_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RECV,
        ST_STAT,
        ST_DISC,
        ST_PEND
    } rxov_state_e;

    localparam logic KIND_DATA = 1'b0;
    localparam logic KIND_STAT = 1'b1;

    typedef struct packed {
        logic wr_data;
        logic wr_stat;
        logic ov;
        logic len_clr;
        logic len_inc;
        logic drop;
    } rxov_act_t;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rxov_ctrl.sv
module rxov_ctrl
    import rxov_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      in_valid,
    input  logic      in_sof,
    input  logic      in_eof,
    input  logic      fifo_full,
    output rxov_act_t act
);

    rxov_state_e state, nxt;

    always_comb begin
        act = '0;
        nxt = state;
        case (state)
            ST_IDLE: begin
                if (in_valid && in_sof) begin
                    act.len_clr = 1'b1;
                    if (!fifo_full) begin
                        act.wr_data = 1'b1;
                        act.len_inc = 1'b1;
                        nxt = in_eof ? ST_STAT : ST_RECV;
                    end else begin
                        act.drop = 1'b1;
                        nxt = in_eof ? ST_PEND : ST_DISC;
                    end
                end
            end
            ST_RECV: begin
                if (in_valid) begin
                    if (!fifo_full) begin
                        act.wr_data = 1'b1;
                        act.len_inc = 1'b1;
                        if (in_eof) nxt = ST_STAT;
                    end else begin
                        act.drop = 1'b1;
                        nxt = in_eof ? ST_PEND : ST_DISC;
                    end
                end
            end
            ST_STAT: begin
                if (!fifo_full) begin
                    act.wr_stat = 1'b1;
                    nxt = ST_IDLE;
                end else begin
                    nxt = ST_PEND;
                end
            end
            ST_DISC: begin
                if (in_valid && in_eof) nxt = ST_PEND;
            end
            ST_PEND: begin
                if (in_valid && in_sof) act.drop = 1'b1;
                if (!fifo_full) begin
                    act.wr_stat = 1'b1;
                    act.ov      = 1'b1;
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

endmodule

// File: rtl/rxov_len_cnt.sv
module rxov_len_cnt #(
    parameter int LEN_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             inc,
    output logic [LEN_W-1:0] len
);

    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)             len <= '0;
        else if (clr)        len <= inc ? LEN_W'(1) : '0;
        else if (inc && len != LEN_MAX) len <= len + LEN_W'(1);
    end

endmodule

// File: rtl/rxov_drop_cnt.sv
module rxov_drop_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst)                         count <= '0;
        else if (inc && count != CNT_MAX) count <= count + CNT_W'(1);
    end

endmodule

// File: rtl/rxov_handler.sv
module rxov_handler
    import rxov_pkg::*;
#(
    parameter  int DATA_W = 8,
    parameter  int LEN_W  = 12,
    parameter  int CNT_W  = 8,
    localparam int PAY_W  = max2(DATA_W, LEN_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [DATA_W-1:0] in_data,
    input  logic              fifo_full,
    output logic              fifo_wr,
    output logic [PAY_W:0]    fifo_wdata,
    output logic [CNT_W-1:0]  drop_count
);

    rxov_act_t        act;
    logic [LEN_W-1:0] len;

    rxov_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_eof    (in_eof),
        .fifo_full (fifo_full),
        .act       (act)
    );

    rxov_len_cnt #(.LEN_W(LEN_W)) u_len (
        .clk (clk),
        .rst (rst),
        .clr (act.len_clr),
        .inc (act.len_inc),
        .len (len)
    );

    rxov_drop_cnt #(.CNT_W(CNT_W)) u_drop (
        .clk   (clk),
        .rst   (rst),
        .inc   (act.drop),
        .count (drop_count)
    );

    always_comb begin
        fifo_wr    = act.wr_data | act.wr_stat;
        fifo_wdata = '0;
        if (act.wr_stat) begin
            fifo_wdata[PAY_W]       = KIND_STAT;
            fifo_wdata[LEN_W]       = act.ov;
            fifo_wdata[LEN_W-1:0]   = len;
        end else if (act.wr_data) begin
            fifo_wdata[PAY_W]       = KIND_DATA;
            fifo_wdata[DATA_W-1:0]  = in_data;
        end
    end

endmodule

// File: rtl/rxov_handler_chk.sv
module rxov_handler_chk #(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 12,
    parameter int CNT_W  = 8,
    parameter int PAY_W  = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_sof,
    input logic              in_eof,
    input logic [DATA_W-1:0] in_data,
    input logic              fifo_full,
    input logic              fifo_wr,
    input logic [PAY_W:0]    fifo_wdata,
    input logic [CNT_W-1:0]  drop_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic is_stat;
    assign is_stat = fifo_wdata[PAY_W];

    assert_no_write_full_R4: assert property (@(posedge clk) disable iff (rst)
        fifo_wr |-> !fifo_full);

    assert_data_passthrough_R2: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && !is_stat) |-> (in_valid && fifo_wdata[DATA_W-1:0] == in_data));

    assert_plain_status_after_eof_R3: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && is_stat && !fifo_wdata[LEN_W]) |-> $past(in_valid && in_eof));

    assert_count_step_R7: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (drop_count == $past(drop_count) ||
                  drop_count == CNT_W'($past(drop_count) + CNT_W'(1))));

    assert_same_cycle_drop_R8: assert property (@(posedge clk) disable iff (rst)
        (fifo_wr && is_stat && fifo_wdata[LEN_W] && in_valid && in_sof && drop_count != CNT_MAX)
        |=> drop_count == CNT_W'($past(drop_count) + CNT_W'(1)));

endmodule

bind rxov_handler rxov_handler_chk #(
    .DATA_W (DATA_W),
    .LEN_W  (LEN_W),
    .CNT_W  (CNT_W),
    .PAY_W  (PAY_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_sof     (in_sof),
    .in_eof     (in_eof),
    .in_data    (in_data),
    .fifo_full  (fifo_full),
    .fifo_wr    (fifo_wr),
    .fifo_wdata (fifo_wdata),
    .drop_count (drop_count)
);

// File: tb/tb_rxov_handler.sv
module tb_rxov_handler;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 8;
    localparam int LEN_W  = 12;
    localparam int CNT_W  = 8;
    localparam int PAY_W  = 13;

    typedef struct packed {
        logic        v;
        logic        s;
        logic        e;
        logic [7:0]  d;
        logic        full;
        logic        wr;
        logic        kind;
        logic [12:0] pay;
        logic [7:0]  cnt;
    } vec_t;

    localparam int NV = 27;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b0,8'h00,1'b0, 1'b0,1'b0,13'h0000,8'd0}, // 0  R1 idle
        '{1'b1,1'b0,1'b0,8'hAA,1'b0, 1'b0,1'b0,13'h0000,8'd0}, // 1  R11 stray byte
        '{1'b1,1'b1,1'b0,8'h11,1'b0, 1'b1,1'b0,13'h0011,8'd0}, // 2  R2
        '{1'b1,1'b0,1'b0,8'h22,1'b0, 1'b1,1'b0,13'h0022,8'd0}, // 3  R2
        '{1'b1,1'b0,1'b1,8'h33,1'b0, 1'b1,1'b0,13'h0033,8'd0}, // 4  R2
        '{1'b0,1'b0,1'b0,8'h00,1'b0, 1'b1,1'b1,13'h0003,8'd0}, // 5  R3 status len 3
        '{1'b1,1'b1,1'b1,8'h44,1'b0, 1'b1,1'b0,13'h0044,8'd0}, // 6  R2 one-byte frame
        '{1'b0,1'b0,1'b0,8'h00,1'b1, 1'b0,1'b0,13'h0000,8'd0}, // 7  R10 status held
        '{1'b0,1'b0,1'b0,8'h00,1'b0, 1'b1,1'b1,13'h1001,8'd0}, // 8  R10 ov status len 1
        '{1'b1,1'b1,1'b0,8'h55,1'b0, 1'b1,1'b0,13'h0055,8'd0}, // 9  R2
        '{1'b1,1'b0,1'b0,8'h66,1'b1, 1'b0,1'b0,13'h0000,8'd0}, // 10 R4 overrun
        '{1'b1,1'b0,1'b0,8'h77,1'b0, 1'b0,1'b0,13'h0000,8'd1}, // 11 R4 space back, discard
        '{1'b1,1'b0,1'b1,8'h88,1'b0, 1'b0,1'b0,13'h0000,8'd1}, // 12 R4
        '{1'b0,1'b0,1'b0,8'h00,1'b1, 1'b0,1'b0,13'h0000,8'd1}, // 13 R5 pending
        '{1'b1,1'b1,1'b0,8'h99,1'b1, 1'b0,1'b0,13'h0000,8'd1}, // 14 R6 dropped start
        '{1'b1,1'b0,1'b0,8'h9A,1'b1, 1'b0,1'b0,13'h0000,8'd2}, // 15 R6
        '{1'b1,1'b0,1'b1,8'h9B,1'b1, 1'b0,1'b0,13'h0000,8'd2}, // 16 R6
        '{1'b1,1'b1,1'b0,8'hA0,1'b0, 1'b1,1'b1,13'h1001,8'd2}, // 17 R8 status + drop
        '{1'b1,1'b0,1'b0,8'hA1,1'b0, 1'b0,1'b0,13'h0000,8'd3}, // 18 R6 rest ignored
        '{1'b1,1'b0,1'b1,8'hA2,1'b0, 1'b0,1'b0,13'h0000,8'd3}, // 19 R6
        '{1'b1,1'b1,1'b1,8'hB0,1'b0, 1'b1,1'b0,13'h00B0,8'd3}, // 20 R9 normal frame
        '{1'b0,1'b0,1'b0,8'h00,1'b0, 1'b1,1'b1,13'h0001,8'd3}, // 21 R9 status
        '{1'b0,1'b0,1'b0,8'h00,1'b0, 1'b0,1'b0,13'h0000,8'd3}, // 22 R5 only one ov word
        '{1'b1,1'b1,1'b0,8'hC0,1'b1, 1'b0,1'b0,13'h0000,8'd3}, // 23 R5 first byte full
        '{1'b1,1'b0,1'b1,8'hC1,1'b0, 1'b0,1'b0,13'h0000,8'd4}, // 24 R4
        '{1'b0,1'b0,1'b0,8'h00,1'b0, 1'b1,1'b1,13'h1000,8'd4}, // 25 R5 ov len 0
        '{1'b0,1'b0,1'b0,8'h00,1'b0, 1'b0,1'b0,13'h0000,8'd4}  // 26 R7
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid, in_sof, in_eof, fifo_full;
    logic [DATA_W-1:0] in_data;
    logic              fifo_wr;
    logic [PAY_W:0]    fifo_wdata;
    logic [CNT_W-1:0]  drop_count;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxov_handler #(.DATA_W(DATA_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) dut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_eof     (in_eof),
        .in_data    (in_data),
        .fifo_full  (fifo_full),
        .fifo_wr    (fifo_wr),
        .fifo_wdata (fifo_wdata),
        .drop_count (drop_count)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic s, input logic e,
                         input logic [7:0] d, input logic full);
        @(negedge clk);
        in_valid = v; in_sof = s; in_eof = e; in_data = d; fifo_full = full;
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        in_valid = 0; in_sof = 0; in_eof = 0; in_data = '0; fifo_full = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 count after reset", 32'(drop_count), 32'd0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].v, TBL[i].s, TBL[i].e, TBL[i].d, TBL[i].full);
            check($sformatf("R%0s row %0d wr", "x", i), 32'(fifo_wr), 32'(TBL[i].wr));
            check($sformatf("R7 row %0d count", i), 32'(drop_count), 32'(TBL[i].cnt));
            if (TBL[i].wr)
                check($sformatf("R2/R3/R5 row %0d entry", i), 32'(fifo_wdata),
                      32'({TBL[i].kind, TBL[i].pay}));
        end

        // R7: saturation, one-byte frames dropped every cycle while full
        drive(1'b1, 1'b1, 1'b1, 8'hD0, 1'b1);
        for (int k = 0; k < 300; k++) begin
            drive(1'b1, 1'b1, 1'b1, 8'(k), 1'b1);
            check("R4 no write while full", 32'(fifo_wr), 32'd0);
        end
        check("R7 saturated count", 32'(drop_count), 32'd255);

        // R1: reset while pending, then space returns: no stale status
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
        rst = 1'b1;
        @(posedge clk);
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        rst = 1'b0;
        check("R1 count cleared", 32'(drop_count), 32'd0);
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R1 no status after reset", 32'(fifo_wr), 32'd0);
        drive(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
        check("R1 still idle", 32'(fifo_wr), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule